// File: doc/BRIEF.md
# Boolean Condition Register File

This block holds sixteen one-bit condition flags and a small logic unit that combines them. A single operation per cycle can be issued. A pairwise operation reads two flags and writes either their AND or the first ANDed with the inverse of the second. A group operation reads an aligned run of four or eight flags and writes one bit: the AND of the run ("all true") or the OR of the run ("any true"). The result always lands in the flag named by the destination index.

A separate load port lets a comparison unit deposit a flag value directly, since logic operations alone cannot create a true flag from an all-false file. A combinational read port returns any one flag for a branch unit. All writes happen on the rising clock edge, so the read port shows the value from before the edge. A group base that is not aligned to the group size raises an error flag in the same cycle and blocks the write.

Top module: `boolrf_unit`

## Requirements
- R1: After reset every one of the sixteen flags reads 0.
- R2: `rd_val` equals flag `rd_idx` combinationally; a write issued in the current cycle becomes visible only after the next rising edge.
- R3: With `op_valid` high and `op_code` 0, flag `dst` receives flag `src_a` AND flag `src_b`.
- R4: With `op_code` 1, flag `dst` receives flag `src_a` AND NOT flag `src_b`.
- R5: With `op_code` 2 and `src_a` a multiple of 4, flag `dst` receives the AND of flags `src_a` to `src_a`+3.
- R6: With `op_code` 3 and `src_a` a multiple of 4, flag `dst` receives the OR of flags `src_a` to `src_a`+3.
- R7: With `op_code` 4 (AND) or 5 (OR) and `src_a` equal to 0 or 8, flag `dst` receives the reduction of flags `src_a` to `src_a`+7.
- R8: A group operation whose base is not aligned to its group size drives `op_err` high in the same cycle and changes no flag.
- R9: Codes 6 and 7, and any cycle with `op_valid` low, change no flag and keep `op_err` low.
- R10: A logic operation changes only flag `dst`; when `dst` lies inside its own source group, the sources are read before the write.
- R11: With `ld_we` high, flag `ld_idx` receives `ld_val`; when a logic write targets the same flag in that cycle, the logic result wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Issue an operation this cycle |
| op_code | input | 3 | Operation select (0..5 defined, 6..7 no operation) |
| src_a | input | 4 | First source flag, or group base |
| src_b | input | 4 | Second source flag for pairwise operations |
| dst | input | 4 | Destination flag |
| ld_we | input | 1 | Direct load enable |
| ld_idx | input | 4 | Flag written by the direct load |
| ld_val | input | 1 | Value written by the direct load |
| rd_idx | input | 4 | Flag selected for the read port |
| rd_val | output | 1 | Value of flag `rd_idx` |
| op_err | output | 1 | Misaligned group base in the current operation |

## Verification
The hardest case to reach is a group reduction whose outcome depends on every member of the group, because all flags start false and the only way to make a group partly or fully true is through the load port. The stimulus first loads chosen patterns, then runs reductions with exactly one member off (or on) so that a wrong group bound or a wrong group select shows up. A long random phase mixes loads, logic writes into their own source groups, misaligned bases and load/logic collisions on one flag, while a reference model in the bench checks the read port and error flag every cycle.

// File: rtl/boolrf_pkg.sv
package boolrf_pkg;
   typedef enum logic [2:0] {
      OP_AND  = 3'd0,
      OP_ANDC = 3'd1,
      OP_ALL4 = 3'd2,
      OP_ANY4 = 3'd3,
      OP_ALL8 = 3'd4,
      OP_ANY8 = 3'd5,
      OP_RSV6 = 3'd6,
      OP_RSV7 = 3'd7
   } bop_e;

   localparam int NUM_GROUP_SIZES = 2;   // quads and octets
   localparam int BASE_GROUP      = 4;
endpackage

// File: rtl/boolrf_reduce.sv
// Reduces one aligned group of flags selected by a base index.
module boolrf_reduce #(
   parameter int N   = 16,
   parameter int IW  = 4,
   parameter int GRP = 4
) (
   input  logic [N-1:0]  regs_i,
   input  logic [IW-1:0] base_i,
   output logic          all_o,
   output logic          any_o,
   output logic          misaligned_o
);
   localparam int GW = $clog2(GRP);
   localparam int NG = N / GRP;

   if (GRP < 2 || (1 << GW) != GRP || (N % GRP) != 0 || NG < 2) begin : g_bad
      $error("boolrf_reduce: group size must be a power of two dividing N at least twice");
   end

   logic [NG-1:0]    grp_all;
   logic [NG-1:0]    grp_any;
   logic [IW-GW-1:0] grp_sel;

   for (genvar g = 0; g < NG; g++) begin : g_grp
      assign grp_all[g] = &regs_i[g*GRP +: GRP];
      assign grp_any[g] = |regs_i[g*GRP +: GRP];
   end

   assign grp_sel      = base_i[IW-1:GW];
   assign all_o        = grp_all[grp_sel];
   assign any_o        = grp_any[grp_sel];
   assign misaligned_o = |base_i[GW-1:0];
endmodule

// File: rtl/boolrf_exec.sv
// Decodes the operation and produces the write request and error flag.
module boolrf_exec
   import boolrf_pkg::*;
#(
   parameter int N  = 16,
   parameter int IW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  regs_i,
   input  logic          valid_i,
   input  bop_e          op_i,
   input  logic [IW-1:0] a_i,
   input  logic [IW-1:0] b_i,
   output logic          we_o,
   output logic          val_o,
   output logic          err_o
);
   logic [NUM_GROUP_SIZES-1:0] red_all;
   logic [NUM_GROUP_SIZES-1:0] red_any;
   logic [NUM_GROUP_SIZES-1:0] red_mis;

   for (genvar k = 0; k < NUM_GROUP_SIZES; k++) begin : g_red
      boolrf_reduce #(.N(N), .IW(IW), .GRP(BASE_GROUP << k)) u_red (
         .regs_i       (regs_i),
         .base_i       (a_i),
         .all_o        (red_all[k]),
         .any_o        (red_any[k]),
         .misaligned_o (red_mis[k])
      );
   end

   always_comb begin
      we_o  = 1'b0;
      val_o = 1'b0;
      err_o = 1'b0;
      if (valid_i) begin
         unique case (op_i)
            OP_AND:  begin we_o = 1'b1; val_o = regs_i[a_i] & regs_i[b_i];  end
            OP_ANDC: begin we_o = 1'b1; val_o = regs_i[a_i] & ~regs_i[b_i]; end
            OP_ALL4, OP_ANY4: begin
               err_o = red_mis[0];
               we_o  = ~red_mis[0];
               val_o = (op_i == OP_ALL4) ? red_all[0] : red_any[0];
            end
            OP_ALL8, OP_ANY8: begin
               err_o = red_mis[1];
               we_o  = ~red_mis[1];
               val_o = (op_i == OP_ALL8) ? red_all[1] : red_any[1];
            end
            default: ;
         endcase
      end
   end

   // R8: misaligned quad base flags an error and requests no write
   p_quad_misalign_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && (op_i == OP_ALL4 || op_i == OP_ANY4) && a_i[1:0] != 2'b00)
      |-> (err_o && !we_o));

   // R9: reserved codes stay quiet
   p_reserved_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && (op_i == OP_RSV6 || op_i == OP_RSV7)) |-> (!we_o && !err_o));
endmodule

// File: rtl/boolrf_store.sv
// Flag storage with one logic write port, one load port and one read port.
module boolrf_store #(
   parameter int N  = 16,
   parameter int IW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          lw_we_i,
   input  logic [IW-1:0] lw_idx_i,
   input  logic          lw_val_i,
   input  logic          ld_we_i,
   input  logic [IW-1:0] ld_idx_i,
   input  logic          ld_val_i,
   input  logic [IW-1:0] rd_idx_i,
   output logic          rd_val_o,
   output logic [N-1:0]  regs_o
);
   localparam logic [N-1:0] ONE_HOT0 = {{(N-1){1'b0}}, 1'b1};

   logic [N-1:0] regs_q;
   logic [N-1:0] regs_d;

   always_comb begin
      regs_d = regs_q;
      if (ld_we_i) regs_d[ld_idx_i] = ld_val_i;
      if (lw_we_i) regs_d[lw_idx_i] = lw_val_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) regs_q <= '0;
      else        regs_q <= regs_d;
   end

   assign rd_val_o = regs_q[rd_idx_i];
   assign regs_o   = regs_q;

   // R10: a logic write alone touches only its destination flag
   p_only_dst_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (lw_we_i && !ld_we_i)
      |=> (((regs_q ^ $past(regs_q)) & ~(ONE_HOT0 << $past(lw_idx_i))) == '0));

   // R11: a load lands unless a logic write claims the same flag
   p_load_lands_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_we_i && !(lw_we_i && lw_idx_i == ld_idx_i))
      |=> (regs_q[$past(ld_idx_i)] == $past(ld_val_i)));
endmodule

// File: rtl/boolrf_unit.sv
module boolrf_unit
   import boolrf_pkg::*;
#(
   parameter int NUM_FLAGS = 16,
   localparam int IW       = $clog2(NUM_FLAGS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          op_valid,
   input  logic [2:0]    op_code,
   input  logic [IW-1:0] src_a,
   input  logic [IW-1:0] src_b,
   input  logic [IW-1:0] dst,
   input  logic          ld_we,
   input  logic [IW-1:0] ld_idx,
   input  logic          ld_val,
   input  logic [IW-1:0] rd_idx,
   output logic          rd_val,
   output logic          op_err
);
   if ((1 << IW) != NUM_FLAGS || NUM_FLAGS < 16) begin : g_bad_cfg
      $error("boolrf_unit: NUM_FLAGS must be a power of two of at least 16");
   end

   bop_e           op_e;
   logic [NUM_FLAGS-1:0] regs_w;
   logic           lw_we;
   logic           lw_val;

   assign op_e = bop_e'(op_code);

   boolrf_exec #(.N(NUM_FLAGS), .IW(IW)) u_exec (
      .clk     (clk),
      .rst_n   (rst_n),
      .regs_i  (regs_w),
      .valid_i (op_valid),
      .op_i    (op_e),
      .a_i     (src_a),
      .b_i     (src_b),
      .we_o    (lw_we),
      .val_o   (lw_val),
      .err_o   (op_err)
   );

   boolrf_store #(.N(NUM_FLAGS), .IW(IW)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .lw_we_i  (lw_we),
      .lw_idx_i (dst),
      .lw_val_i (lw_val),
      .ld_we_i  (ld_we),
      .ld_idx_i (ld_idx),
      .ld_val_i (ld_val),
      .rd_idx_i (rd_idx),
      .rd_val_o (rd_val),
      .regs_o   (regs_w)
   );

   // R3: pairwise AND result appears in the destination after the edge
   p_and_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_e == OP_AND)
      |=> (regs_w[$past(dst)] == ($past(regs_w[src_a]) & $past(regs_w[src_b]))));

   // R8: a flagged error leaves every flag untouched when no load is pending
   p_err_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_err && !ld_we) |=> $stable(regs_w));
endmodule

// File: tb/sim_boolrf_unit.sv
module sim_boolrf_unit;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       op_valid;
   logic [2:0] op_code;
   logic [3:0] src_a, src_b, dst, ld_idx, rd_idx;
   logic       ld_we, ld_val;
   logic       rd_val, op_err;

   int checks = 0;
   int errors = 0;
   bit [15:0] m;   // reference copy of the flags

   always #2 clk = ~clk;   // 250 MHz

   boolrf_unit u0 (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .src_a(src_a), .src_b(src_b), .dst(dst), .ld_we(ld_we), .ld_idx(ld_idx),
      .ld_val(ld_val), .rd_idx(rd_idx), .rd_val(rd_val), .op_err(op_err)
   );

   task automatic check(input bit got, input bit exp, input string tag, input string what);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0b expected=%0b", tag, what, got, exp);
      end
   endtask

   // One cycle: drive at the falling edge, check before the rising edge, update the model.
   task automatic step(input bit v, input [2:0] oc, input [3:0] a, input [3:0] b, input [3:0] d,
                       input bit ew, input [3:0] ei, input bit ev, input [3:0] ri, input string tag);
      bit ex_err, ex_we, ex_val;
      int gsz;
      @(negedge clk);
      op_valid = v; op_code = oc; src_a = a; src_b = b; dst = d;
      ld_we = ew; ld_idx = ei; ld_val = ev; rd_idx = ri;
      ex_err = 0; ex_we = 0; ex_val = 0;
      if (v) begin
         case (oc)
            3'd0: begin ex_we = 1; ex_val = m[a] & m[b]; end
            3'd1: begin ex_we = 1; ex_val = m[a] & !m[b]; end
            3'd2, 3'd3, 3'd4, 3'd5: begin
               gsz = (oc < 3'd4) ? 4 : 8;
               if ((int'(a) % gsz) != 0) ex_err = 1;
               else begin
                  ex_we = 1;
                  ex_val = (oc == 3'd2 || oc == 3'd4) ? 1'b1 : 1'b0;
                  for (int i = 0; i < gsz; i++) begin
                     if (oc == 3'd2 || oc == 3'd4) ex_val = ex_val && m[int'(a) + i];
                     else                          ex_val = ex_val || m[int'(a) + i];
                  end
               end
            end
            default: ;
         endcase
      end
      #1;
      check(rd_val, m[ri], tag, "rd_val");
      check(op_err, ex_err, tag, "op_err");
      @(posedge clk);
      if (ew) m[ei] = ev;
      if (ex_we) m[d] = ex_val;
   endtask

   task automatic idle_read(input [3:0] ri, input string tag);
      step(0, 3'd0, 0, 0, 0, 0, 0, 0, ri, tag);
   endtask

   task automatic sweep(input string tag);
      for (int i = 0; i < 16; i++) idle_read(4'(i), tag);
   endtask

   task automatic load(input [3:0] i, input bit v);
      step(0, 3'd0, 0, 0, 0, 1, i, v, i, "R11");
   endtask

   task automatic op(input [2:0] oc, input [3:0] a, input [3:0] b, input [3:0] d, input string tag);
      step(1, oc, a, b, d, 0, 0, 0, d, tag);
   endtask

   initial begin
      #(4 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      m = '0;
      rst_n = 0; op_valid = 0; op_code = 0; src_a = 0; src_b = 0; dst = 0;
      ld_we = 0; ld_idx = 0; ld_val = 0; rd_idx = 0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      sweep("R1");

      // R11: load a pattern, then read back after the edge
      load(4'd1, 1); load(4'd2, 1); load(4'd3, 1);
      idle_read(4'd1, "R11"); idle_read(4'd3, "R11");
      // R3 pairwise AND, true and false cases
      op(3'd0, 4'd1, 4'd2, 4'd9, "R3");  idle_read(4'd9, "R3");
      op(3'd0, 4'd1, 4'd0, 4'd9, "R3");  idle_read(4'd9, "R3");
      // R4 AND-with-complement
      op(3'd1, 4'd1, 4'd0, 4'd10, "R4"); idle_read(4'd10, "R4");
      op(3'd1, 4'd1, 4'd2, 4'd10, "R4"); idle_read(4'd10, "R4");
      // R5/R6 quad 0: one member false, then all true
      op(3'd2, 4'd0, 4'd0, 4'd11, "R5"); idle_read(4'd11, "R5");
      op(3'd3, 4'd0, 4'd0, 4'd12, "R6"); idle_read(4'd12, "R6");
      load(4'd0, 1);
      op(3'd2, 4'd0, 4'd0, 4'd11, "R5"); idle_read(4'd11, "R5");
      op(3'd3, 4'd4, 4'd0, 4'd12, "R6"); idle_read(4'd12, "R6");
      // R7 octets
      op(3'd4, 4'd0, 4'd0, 4'd13, "R7"); idle_read(4'd13, "R7");
      op(3'd5, 4'd8, 4'd0, 4'd14, "R7"); idle_read(4'd14, "R7");
      for (int i = 4; i < 8; i++) load(4'(i), 1);
      op(3'd4, 4'd0, 4'd0, 4'd13, "R7"); idle_read(4'd13, "R7");
      // R8 misaligned bases leave the file unchanged
      op(3'd2, 4'd5, 4'd0, 4'd0, "R8");
      op(3'd5, 4'd4, 4'd0, 4'd1, "R8");
      op(3'd3, 4'd14, 4'd0, 4'd2, "R8");
      sweep("R8");
      // R9 reserved codes and invalid cycles
      op(3'd6, 4'd0, 4'd0, 4'd0, "R9");
      op(3'd7, 4'd1, 4'd1, 4'd3, "R9");
      step(0, 3'd1, 4'd1, 4'd0, 4'd4, 0, 0, 0, 4'd4, "R9");
      sweep("R9");
      // R10 destination inside its own source group; R2 read shows old value
      op(3'd3, 4'd8, 4'd0, 4'd8, "R10");
      op(3'd2, 4'd0, 4'd0, 4'd2, "R2");
      sweep("R10");
      // R11 collision: logic write beats load on the same flag
      step(1, 3'd1, 4'd1, 4'd15, 4'd15, 1, 4'd15, 0, 4'd15, "R11");
      idle_read(4'd15, "R11");

      for (int n = 0; n < 4000; n++) begin
         bit [2:0] oc = 3'($urandom_range(0, 7));
         bit [3:0] a  = 4'($urandom);
         if ($urandom_range(0, 1) == 1) a = (oc >= 3'd4) ? (a & 4'h8) : (a & 4'hC);
         step($urandom_range(0, 3) != 0, oc, a, 4'($urandom), 4'($urandom),
              $urandom_range(0, 2) == 0, 4'($urandom), 1'($urandom), 4'($urandom), "R10");
      end
      sweep("R2");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule